// File: doc/BRIEF.md
# Multi-Level Trigger Sequencer

This block watches the sampled channel bus of a logic analyzer and decides when the capture should trigger. It steps through a chain of up to eight sequence levels. At each level, a qualifying event is one of four sources: two pattern comparators chosen from a shared pool, and two further event units. In timing mode these two units detect edges on a chosen channel. In state mode they check whether a masked group of channels falls inside a numeric window. Each level must see its qualifying event a programmed number of times before the sequencer moves on to the next enabled level.

Software writes the pattern pool, the two event units and the per-level settings through a simple write-only register port, then pulses `arm`. Once the last enabled level is satisfied, `trig` rises and the active-low `trig_n` falls. Both stay in that state until the next `arm`.

Top module: `trig_seq`

## Requirements
- R1: After reset `trig` is 0 and `trig_n` is 1.
- R2: Pattern slot p matches a sample when `((s_data ^ value) & mask) == 0`. The value register is at address 2p and the mask at 2p+1, so a zero mask always matches.
- R3: Each level has a config word at address 24+2L. Bits [2:0] select pattern A and bits [6:4] select pattern B. Bits 8, 9, 10 and 11 enable pattern A, pattern B, event unit 0 and event unit 1, and bit 15 enables the level. The qualifying event is the OR of the enabled sources, so a level with no source enabled never advances.
- R4: The repeat count sits at address 25+2L. A level is satisfied on the Nth qualifying valid sample after entry, and the counter reloads from the programmed value each time a level is entered or `arm` is pulsed.
- R5: A written repeat count below 2 is stored as 2, and one above the parameter CNT_MAX (default 1,046,575) is stored as CNT_MAX.
- R6: Level 0 is always active after `arm`. When a level is satisfied, the sequencer moves to the lowest enabled level above it and skips disabled ones. If no enabled level lies above it, the block triggers.
- R7: `trig` rises, and `trig_n` falls, on the clock edge that accepts the final qualifying sample. Both then hold with later samples ignored until `arm`.
- R8: `arm` returns the sequencer to level 0 with a reloaded count and clears `trig`. It wins over a sample presented in the same cycle.
- R9: When `mode_state` is 0, event unit e (register 16+4e: bits [3:0] channel, bits [5:4] direction with 0=rise, 1=fall, 2 or 3=either) fires when the selected channel changed in that direction since the previous valid sample. The first valid sample after reset never fires.
- R10: When `mode_state` is 1, event unit e fires when `s_data & mask` (mask at 17+4e), read unsigned, lies between the low bound (18+4e) and the high bound (19+4e), inclusive.
- R11: Cycles with `s_valid` low neither count nor update the previous-sample reference for edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 6 | Configuration register address |
| cfg_wdata | input | 32 | Configuration write data |
| mode_state | input | 1 | 0 = edge events, 1 = range events |
| arm | input | 1 | Restart the sequencer at level 0 |
| s_valid | input | 1 | Sample valid |
| s_data | input | CH_W (16) | Sampled channel values |
| trig | output | 1 | Trigger reached (active high) |
| trig_n | output | 1 | Trigger reached (active low) |

## Verification
The hardest situation to reach is a deep chain in which samples that would satisfy a later level arrive while an earlier level is still active. The sequencer must ignore them, and the later level must still require its full reloaded count after entry. The bench builds a three-level chain with disabled levels in between that would match everything. It feeds the later level's pattern early, then checks that the trigger appears exactly on the final sample, and again when `arm` coincides with that sample.

// File: rtl/trig_seq.sv
module trig_seq #(
  parameter int CH_W    = 16,
  parameter int LEVELS  = 8,
  parameter int PATS    = 8,
  parameter int CNT_W   = 20,
  parameter int CNT_MIN = 2,
  parameter int CNT_MAX = 1046575,
  localparam int EV_BASE = 2 * PATS,
  localparam int LV_BASE = EV_BASE + 8,
  localparam int AW      = $clog2(LV_BASE + 2 * LEVELS),
  localparam int LW      = $clog2(LEVELS),
  localparam int PW      = $clog2(PATS),
  localparam int SW      = $clog2(CH_W)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [AW-1:0]   cfg_addr,
  input  logic [31:0]     cfg_wdata,
  input  logic            mode_state,
  input  logic            arm,
  input  logic            s_valid,
  input  logic [CH_W-1:0] s_data,
  output logic            trig,
  output logic            trig_n
);

  logic [CH_W-1:0]  pval  [PATS];
  logic [CH_W-1:0]  pmask [PATS];
  logic [SW-1:0]    e_ch  [2];
  logic [1:0]       e_dir [2];
  logic [CH_W-1:0]  r_mask[2];
  logic [CH_W-1:0]  r_lo  [2];
  logic [CH_W-1:0]  r_hi  [2];
  logic [PW-1:0]    l_sa  [LEVELS];
  logic [PW-1:0]    l_sb  [LEVELS];
  logic [3:0]       l_use [LEVELS];
  logic             l_en  [LEVELS];
  logic [CNT_W-1:0] l_cnt [LEVELS];

  logic [LW-1:0]    lvl;
  logic [CNT_W-1:0] cnt;
  logic [CH_W-1:0]  prev;
  logic             prev_ok;

  function automatic logic [CNT_W-1:0] clamp(input logic [31:0] v);
    if (v < 32'(CNT_MIN))      return CNT_W'(CNT_MIN);
    else if (v > 32'(CNT_MAX)) return CNT_W'(CNT_MAX);
    else                       return v[CNT_W-1:0];
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < PATS; p++) begin
        pval[p]  <= '0;
        pmask[p] <= '0;
      end
      for (int e = 0; e < 2; e++) begin
        e_ch[e]   <= '0;
        e_dir[e]  <= '0;
        r_mask[e] <= '0;
        r_lo[e]   <= '0;
        r_hi[e]   <= '0;
      end
      for (int l = 0; l < LEVELS; l++) begin
        l_sa[l]  <= '0;
        l_sb[l]  <= '0;
        l_use[l] <= '0;
        l_en[l]  <= 1'b0;
        l_cnt[l] <= CNT_W'(CNT_MIN);
      end
    end else if (cfg_we) begin
      for (int p = 0; p < PATS; p++) begin
        if (cfg_addr == AW'(2 * p))     pval[p]  <= cfg_wdata[CH_W-1:0];
        if (cfg_addr == AW'(2 * p + 1)) pmask[p] <= cfg_wdata[CH_W-1:0];
      end
      for (int e = 0; e < 2; e++) begin
        if (cfg_addr == AW'(EV_BASE + 4 * e)) begin
          e_ch[e]  <= cfg_wdata[SW-1:0];
          e_dir[e] <= cfg_wdata[5:4];
        end
        if (cfg_addr == AW'(EV_BASE + 4 * e + 1)) r_mask[e] <= cfg_wdata[CH_W-1:0];
        if (cfg_addr == AW'(EV_BASE + 4 * e + 2)) r_lo[e]   <= cfg_wdata[CH_W-1:0];
        if (cfg_addr == AW'(EV_BASE + 4 * e + 3)) r_hi[e]   <= cfg_wdata[CH_W-1:0];
      end
      for (int l = 0; l < LEVELS; l++) begin
        if (cfg_addr == AW'(LV_BASE + 2 * l)) begin
          l_sa[l]  <= cfg_wdata[PW-1:0];
          l_sb[l]  <= cfg_wdata[4+PW-1:4];
          l_use[l] <= cfg_wdata[11:8];
          l_en[l]  <= cfg_wdata[15];
        end
        if (cfg_addr == AW'(LV_BASE + 2 * l + 1)) l_cnt[l] <= clamp(cfg_wdata);
      end
    end
  end

  logic [PATS-1:0] pat_hit;
  logic [1:0]      ev_hit;

  for (genvar p = 0; p < PATS; p++) begin : g_pat
    assign pat_hit[p] = ((s_data ^ pval[p]) & pmask[p]) == '0;
  end

  for (genvar e = 0; e < 2; e++) begin : g_ev
    logic            now_b, old_b, edge_hit, range_hit;
    logic [CH_W-1:0] grp;
    assign now_b     = s_data[e_ch[e]];
    assign old_b     = prev[e_ch[e]];
    assign edge_hit  = prev_ok && ((e_dir[e] == 2'd0) ? (!old_b && now_b) :
                                   (e_dir[e] == 2'd1) ? (old_b && !now_b) :
                                                        (old_b != now_b));
    assign grp       = s_data & r_mask[e];
    assign range_hit = (grp >= r_lo[e]) && (grp <= r_hi[e]);
    assign ev_hit[e] = mode_state ? range_hit : edge_hit;
  end

  logic [3:0] src;
  logic       qual;
  assign src  = {ev_hit[1], ev_hit[0], pat_hit[l_sb[lvl]], pat_hit[l_sa[lvl]]};
  assign qual = s_valid && !trig && ((src & l_use[lvl]) != 4'd0);

  logic [LW-1:0] nxt;
  logic          nxt_ok;
  always_comb begin
    nxt    = '0;
    nxt_ok = 1'b0;
    for (int i = LEVELS - 1; i > 0; i--) begin
      if (LW'(i) > lvl && l_en[i]) begin
        nxt    = LW'(i);
        nxt_ok = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl  <= '0;
      cnt  <= CNT_W'(CNT_MIN);
      trig <= 1'b0;
    end else if (arm) begin
      lvl  <= '0;
      cnt  <= l_cnt[0];
      trig <= 1'b0;
    end else if (qual) begin
      if (cnt == CNT_W'(1)) begin
        if (nxt_ok) begin
          lvl <= nxt;
          cnt <= l_cnt[nxt];
        end else begin
          trig <= 1'b1;
        end
      end else begin
        cnt <= cnt - CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev    <= '0;
      prev_ok <= 1'b0;
    end else if (s_valid) begin
      prev    <= s_data;
      prev_ok <= 1'b1;
    end
  end

  assign trig_n = !trig;

endmodule

// File: rtl/trig_seq_chk.sv
module trig_seq_chk #(
  parameter int LW      = 3,
  parameter int CNT_W   = 20,
  parameter int CNT_MAX = 1046575
) (
  input logic             clk,
  input logic             rst_n,
  input logic             arm,
  input logic             s_valid,
  input logic             trig,
  input logic [LW-1:0]    lvl,
  input logic [CNT_W-1:0] cnt
);

  AST_TRIG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    trig && !arm |=> trig); // R7

  AST_TRIG_ON_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trig) |-> $past(s_valid)); // R7

  AST_ARM_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> !trig && lvl == '0); // R8

  AST_CNT_IN_BOUNDS: assert property (@(posedge clk) disable iff (!rst_n)
    cnt >= CNT_W'(1) && cnt <= CNT_W'(CNT_MAX)); // R5

  AST_LEVEL_MONOTONIC: assert property (@(posedge clk) disable iff (!rst_n)
    !arm |=> lvl >= $past(lvl)); // R6

  AST_IDLE_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    !s_valid && !arm |=> $stable(lvl) && $stable(cnt) && $stable(trig)); // R11

endmodule

bind trig_seq trig_seq_chk #(.LW(LW), .CNT_W(CNT_W), .CNT_MAX(CNT_MAX)) i_chk (
  .clk(clk), .rst_n(rst_n), .arm(arm), .s_valid(s_valid),
  .trig(trig), .lvl(lvl), .cnt(cnt)
);

// File: tb/test_trig_seq.sv
module test_trig_seq;
  localparam int CMAX = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [5:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        mode_state = 1'b0;
  logic        arm = 1'b0;
  logic        s_valid = 1'b0;
  logic [15:0] s_data = '0;
  logic        trig, trig_n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = !clk;

  trig_seq #(.CNT_MAX(CMAX)) i_trig_seq (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .mode_state(mode_state), .arm(arm),
    .s_valid(s_valid), .s_data(s_data), .trig(trig), .trig_n(trig_n)
  );

  function automatic logic [31:0] lv(int sa, int sb, int use4, bit en);
    return (32'(en) << 15) | (32'(use4) << 8) | (32'(sb) << 4) | 32'(sa);
  endfunction

  function automatic bit edge_fire(int dir, bit o, bit n);
    if (dir == 0) return !o && n;
    if (dir == 1) return o && !n;
    return o != n;
  endfunction

  task automatic chk(bit exp, string req);
    checks++;
    if (trig !== exp || trig_n !== !exp) begin
      errors++;
      $display("FAIL %s: trig=%b trig_n=%b expected trig=%b trig_n=%b",
               req, trig, trig_n, exp, !exp);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    cfg_we = 1'b1; cfg_addr = 6'(a); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic do_arm();
    arm = 1'b1;
    @(negedge clk);
    arm = 1'b0;
  endtask

  task automatic smp(logic [15:0] d);
    s_valid = 1'b1; s_data = d;
    @(negedge clk);
    s_valid = 1'b0;
  endtask

  task automatic idle(logic [15:0] d);
    s_valid = 1'b0; s_data = d;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(1'b0, "R1 reset state");

    // R9: edge mode sweep, channel 3, all direction codes
    begin
      bit bprev = 1'b0;
      bit bprev_ok = 1'b0;
      for (int dir = 0; dir < 4; dir++) begin
        for (int sq = 0; sq < 3; sq++) begin
          logic [7:0] seq;
          int c = 0;
          bit texp = 1'b0;
          seq = (sq == 0) ? 8'b0101_0101 : (sq == 1) ? 8'b1100_1101 : 8'b0011_1010;
          wr(16, 32'(3) | (32'(dir) << 4));
          wr(17, 32'h0); wr(18, 32'h0); wr(19, 32'hFFFF);
          wr(24, lv(0, 0, 4'b0100, 1'b0));
          wr(25, 32'd2);
          mode_state = 1'b0;
          do_arm();
          for (int k = 0; k < 8; k++) begin
            bit b = seq[k];
            logic [15:0] d;
            d = (16'((k + 1) * 1237) & 16'hFFF7) | (16'(b) << 3);
            if (bprev_ok && edge_fire(dir, bprev, b) && !texp) begin
              c++;
              if (c == 2) texp = 1'b1;
            end
            if (k == 3) idle(d ^ 16'h0008);
            smp(d);
            bprev = b; bprev_ok = 1'b1;
            chk(texp, "R9 edge event");
          end
        end
      end
    end

    // R2 + R5(min clamp): pattern sweep over masked byte
    wr(0, 32'h0000_00A5);
    wr(1, 32'h0000_00FF);
    wr(24, lv(0, 0, 4'b0001, 1'b0));
    wr(25, 32'd0);
    for (int i = 0; i < 256; i++) begin
      logic [15:0] d;
      d = {8'(i * 37), 8'(i)};
      do_arm();
      smp(d);
      chk(1'b0, "R5 count 0 stored as 2");
      smp(d);
      chk(i == 8'hA5, "R2 pattern match");
    end
    wr(25, 32'd1);
    do_arm();
    smp(16'h77A5);
    chk(1'b0, "R5 count 1 stored as 2");
    smp(16'h00A5);
    chk(1'b1, "R5 count 1 stored as 2");

    // R4 + R11: count sweep with invalid matching cycles and misses
    for (int n = 2; n <= CMAX; n++) begin
      wr(25, 32'(n));
      do_arm();
      for (int k = 1; k <= n; k++) begin
        idle(16'h00A5);
        smp(16'h0000);
        chk(1'b0, "R11 invalid/miss ignored");
        smp(16'h12A5);
        chk(k == n, "R4 repeat count");
      end
    end

    // R5: high clamp
    wr(25, 32'd100);
    do_arm();
    for (int k = 1; k <= CMAX; k++) begin
      smp(16'h00A5);
      chk(k == CMAX, "R5 count clamps to max");
    end
    wr(25, 32'hFFFFF);
    do_arm();
    for (int k = 1; k <= CMAX; k++) begin
      smp(16'h00A5);
      chk(k == CMAX, "R5 count clamps to max");
    end

    // R3: no sources never advances; OR of two patterns
    wr(2, 32'h0000_1234);
    wr(3, 32'h0000_FFFF);
    wr(24, lv(0, 1, 4'b0000, 1'b0));
    wr(25, 32'd2);
    do_arm();
    for (int k = 0; k < 20; k++) begin
      smp((k % 2 == 0) ? 16'h00A5 : 16'h1234);
      chk(1'b0, "R3 level with no source");
    end
    wr(24, lv(0, 1, 4'b0011, 1'b0));
    do_arm();
    smp(16'h00A5);
    chk(1'b0, "R3 OR of sources");
    smp(16'h1234);
    chk(1'b1, "R3 OR of sources");

    // R10: range mode sweep of nibble [7:4] against [3,9]
    mode_state = 1'b1;
    wr(20, 32'h0);
    wr(21, 32'h0000_00F0);
    wr(22, 32'h0000_0030);
    wr(23, 32'h0000_0090);
    wr(24, lv(0, 0, 4'b1000, 1'b0));
    for (int n = 0; n < 16; n++) begin
      logic [15:0] d;
      d = (16'(n) << 4) | (16'(n * 4099) & 16'hFF0F);
      do_arm();
      smp(d);
      chk(1'b0, "R10 range event");
      smp(d);
      chk(n >= 3 && n <= 9, "R10 range event");
    end
    mode_state = 1'b0;

    // R6/R4/R7/R8: chain levels 0 -> 2 -> 5, with 1 and 3 disabled
    wr(0, 32'h1111); wr(1, 32'hFFFF);
    wr(2, 32'h2222); wr(3, 32'hFFFF);
    wr(4, 32'h3333); wr(5, 32'hFFFF);
    wr(6, 32'h0);    wr(7, 32'h0);
    wr(24, lv(0, 0, 4'b0001, 1'b0)); wr(25, 32'd2);
    wr(26, lv(3, 3, 4'b0001, 1'b0)); wr(27, 32'd2);
    wr(28, lv(1, 1, 4'b0001, 1'b1)); wr(29, 32'd3);
    wr(30, lv(3, 3, 4'b0001, 1'b0)); wr(31, 32'd2);
    wr(34, lv(2, 2, 4'b0001, 1'b1)); wr(35, 32'd2);
    for (int pass = 0; pass < 2; pass++) begin
      do_arm();
      smp(16'h2222); chk(1'b0, "R6 later pattern ignored in level 0");
      smp(16'h2222); chk(1'b0, "R6 later pattern ignored in level 0");
      smp(16'h1111); chk(1'b0, "R6 chain");
      smp(16'h0000); chk(1'b0, "R6 chain");
      smp(16'h1111); chk(1'b0, "R6 enters level 2");
      smp(16'h2222); chk(1'b0, "R4 reload on entry");
      smp(16'h2222); chk(1'b0, "R4 reload on entry");
      smp(16'h1111); chk(1'b0, "R6 skip disabled levels");
      if (pass == 0) begin
        smp(16'h2222); chk(1'b0, "R6 enters level 5");
        smp(16'h3333); chk(1'b0, "R6 last level count");
        smp(16'h3333); chk(1'b1, "R7 trigger on final sample");
        for (int k = 0; k < 4; k++) begin
          smp(16'h0000); chk(1'b1, "R7 trigger held");
        end
        idle(16'h0); chk(1'b1, "R7 trigger held");
        do_arm(); chk(1'b0, "R8 arm clears");
      end else begin
        smp(16'h2222); smp(16'h3333);
        arm = 1'b1; s_valid = 1'b1; s_data = 16'h3333;
        @(negedge clk);
        arm = 1'b0; s_valid = 1'b0;
        chk(1'b0, "R8 arm wins over sample");
        smp(16'h3333); chk(1'b0, "R8 back at level 0");
      end
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule